// File: doc/BRIEF.md
# Cascadable Dual Timer with 64-bit Joined Mode

Two 32-bit timer/counters either run as separate timers or join into one 64-bit counter. In joined mode the low half passes its carry (counting up) or its borrow (counting down) to the high half. One 64-bit load value then applies, and a single terminal count produces one generate pulse and one interrupt flag. Each timer has a reload sequencer. When the count reaches its terminal value (all zeros counting down, all ones counting up), the sequencer emits a one-cycle generate pulse and raises the interrupt flag. It then either reloads the count and inserts a fixed stall, or stops and holds the terminal value.

Software-side control appears as strobes:
- a per-timer start and a per-timer stop;
- an enable-all write, where writing 1 starts both timers;
- a per-timer load, which copies the load value into the count;
- a write-1-to-clear per interrupt flag.

The direction and the reload-or-hold choice are levels.

Top module: `ct64_timer`

## Requirements
- R1: After reset `count` is 0, `gen_out` and `irq_flag` are 0, and no timer runs until it is started.
- R2: Joined mode with `dir_down[0]`=1 (count down) and `auto_reload[0]`=1: a load L gives the first pulse L+1 cycles after the count first shows L. The following pulses are L+4 cycles apart.
- R3: Joined mode with `dir_down[0]`=0 (count up) and auto-reload: pulses are 2^64-1-L+4 cycles apart. The first pulse comes 2^64-1-L+1 cycles after the count first shows L.
- R4: In joined mode the upper 32 bits of `count` change only when the lower half wraps. Counting down, 0 becomes all ones and the upper half decrements in the same cycle. Counting up, all ones becomes 0 and the upper half increments in the same cycle.
- R5: In joined mode `load_stb[0]` writes `{load_hi, load_lo}` into both halves, and `count` shows the value in the next cycle.
- R6: `all_wr` with `all_wdata`=1 starts both timers in the same cycle. With `all_wdata`=0 it has no effect on a stopped count.
- R7: With `cascade_on`=0 the halves are independent 32-bit timers. `load_lo` feeds the low half and `load_hi` feeds the high half. Each half has its own pulse bit (`gen_out[0]` for low, `gen_out[1]` for high), spaced at its own load+4, with no carry between the halves.
- R8: With auto-reload clear, the terminal count gives exactly one pulse. The timer then stops with the count held at the terminal value.
- R9: An interrupt flag is set one cycle after its terminal count. It stays set until a 1 is written to its `irq_clr` bit, and it reads 0 the cycle after the clear.
- R10: A generate pulse lasts one cycle. With auto-reload, `count` already shows the reloaded load value in the pulse cycle.
- R11: In joined mode `load_stb[1]` and `start_stb[1]` have no effect on `count`, and `gen_out[1]` stays 0.
- R12: A stop strobe freezes the count from the next cycle. A later start resumes it by one step per cycle from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cascade_on | input | 1 | 1 joins both halves into one 64-bit timer |
| all_wr | input | 1 | Enable-all write strobe |
| all_wdata | input | 1 | Data of the enable-all write; 1 starts both timers |
| start_stb | input | 2 | Per-timer start strobe |
| stop_stb | input | 2 | Per-timer stop strobe |
| dir_down | input | 2 | Per-timer direction, 1 counts down |
| auto_reload | input | 2 | Per-timer: 1 reloads at terminal count, 0 stops there |
| load_stb | input | 2 | Per-timer load strobe |
| load_lo | input | 32 | Load value of the low half |
| load_hi | input | 32 | Load value of the high half |
| irq_clr | input | 2 | Write-1-to-clear of the interrupt flags |
| count | output | 64 | {high half, low half} count |
| gen_out | output | 2 | One-cycle generate pulses |
| irq_flag | output | 2 | Sticky terminal-count flags |

## Verification
The checks assume that `cascade_on`, `dir_down` and `auto_reload` are changed only while the affected timers are stopped. They also assume that the load values are steady in the cycle the load strobe is high. Switching mode mid-count would break the link between the carry path and the sequencer that the properties rely on. The stimulus therefore stops both timers with a stop strobe before each phase. It then sets the levels, loads, and only then starts. Load values are chosen so that terminal counts, half-wraps and stalls land inside short windows.

// File: rtl/ct64_pkg.sv
package ct64_pkg;
  localparam int NUM_TMR  = 2;
  localparam int OVERHEAD = 4;
  typedef enum logic {JOIN_SPLIT = 1'b0, JOIN_CASCADE = 1'b1} join_e;
endpackage

// File: rtl/ct64_half.sv
module ct64_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_now,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] value,
  output logic         at_term,
  output logic         wrap
);
  function automatic logic [W-1:0] next_val(input logic [W-1:0] v, input logic dn);
    return dn ? v - W'(1) : v + W'(1);
  endfunction

  function automatic logic [W-1:0] term_val(input logic dn);
    return dn ? '0 : '1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        value <= '0;
    else if (load_now) value <= load_val;
    else if (step)     value <= next_val(value, down);
  end

  assign at_term = (value == term_val(down));
  assign wrap    = step & at_term;
endmodule

// File: rtl/ct64_seq.sv
module ct64_seq #(
  parameter int OVERHEAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic restart,
  input  logic term,
  input  logic auto_rl,
  output logic advance,
  output logic tc_evt,
  output logic reload,
  output logic gen
);
  localparam int STALL_N = OVERHEAD - 1;
  localparam int SW      = $clog2(STALL_N + 1);

  logic [SW-1:0] stall_cnt;
  logic          stalling;

  assign stalling = (stall_cnt != '0);
  assign advance  = go & ~stalling & ~term & ~restart;
  assign tc_evt   = go & ~stalling &  term & ~restart;
  assign reload   = tc_evt & auto_rl;

  always_ff @(posedge clk) begin
    if (!rst_n)                stall_cnt <= '0;
    else if (restart)          stall_cnt <= '0;
    else if (reload)           stall_cnt <= SW'(STALL_N);
    else if (go && stalling)   stall_cnt <= stall_cnt - SW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gen <= 1'b0;
    else        gen <= tc_evt;
  end
endmodule

// File: rtl/ct64_ctrl.sv
module ct64_ctrl
  import ct64_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               all_wr,
  input  logic               all_wdata,
  input  logic [NUM_TMR-1:0] start_stb,
  input  logic [NUM_TMR-1:0] stop_stb,
  input  logic [NUM_TMR-1:0] halt_req,
  input  logic [NUM_TMR-1:0] tc_evt,
  input  logic [NUM_TMR-1:0] irq_clr,
  output logic [NUM_TMR-1:0] run,
  output logic [NUM_TMR-1:0] irq
);
  logic all_set;
  assign all_set = all_wr & all_wdata;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (!rst_n)                         run[i] <= 1'b0;
      else if (halt_req[i] | stop_stb[i]) run[i] <= 1'b0;
      else if (start_stb[i] | all_set)    run[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          irq[i] <= 1'b0;
      else if (tc_evt[i])  irq[i] <= 1'b1;
      else if (irq_clr[i]) irq[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ct64_timer.sv
module ct64_timer
  import ct64_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cascade_on,
  input  logic                all_wr,
  input  logic                all_wdata,
  input  logic [NUM_TMR-1:0]  start_stb,
  input  logic [NUM_TMR-1:0]  stop_stb,
  input  logic [NUM_TMR-1:0]  dir_down,
  input  logic [NUM_TMR-1:0]  auto_reload,
  input  logic [NUM_TMR-1:0]  load_stb,
  input  logic [HALF_W-1:0]   load_lo,
  input  logic [HALF_W-1:0]   load_hi,
  input  logic [NUM_TMR-1:0]  irq_clr,
  output logic [2*HALF_W-1:0] count,
  output logic [NUM_TMR-1:0]  gen_out,
  output logic [NUM_TMR-1:0]  irq_flag
);
  join_e joined_mode;
  logic  joined;

  logic [NUM_TMR-1:0]             run;
  logic [NUM_TMR-1:0]             adv, tc_evt, reload_s, gen_s;
  logic [NUM_TMR-1:0]             seq_go, seq_restart, seq_term, seq_arl;
  logic [NUM_TMR-1:0]             h_load, h_step, h_down, at_term, wrap;
  logic [NUM_TMR-1:0][HALF_W-1:0] h_val, h_ld;
  logic                           unused_wrap_hi;

  assign joined_mode    = cascade_on ? JOIN_CASCADE : JOIN_SPLIT;
  assign joined         = (joined_mode == JOIN_CASCADE);
  assign unused_wrap_hi = wrap[1];

  always_comb begin
    h_ld[0] = load_lo;
    h_ld[1] = load_hi;

    seq_go[0]      = run[0];
    seq_restart[0] = load_stb[0];
    seq_arl[0]     = auto_reload[0];
    seq_term[0]    = joined ? (at_term[0] & at_term[1]) : at_term[0];

    seq_go[1]      = run[1] & ~joined;
    seq_restart[1] = load_stb[1] & ~joined;
    seq_arl[1]     = auto_reload[1];
    seq_term[1]    = at_term[1];

    h_load[0] = load_stb[0] | reload_s[0];
    h_step[0] = adv[0];
    h_down[0] = dir_down[0];

    if (joined) begin
      h_load[1] = load_stb[0] | reload_s[0];
      h_step[1] = wrap[0];
      h_down[1] = dir_down[0];
    end else begin
      h_load[1] = load_stb[1] | reload_s[1];
      h_step[1] = adv[1];
      h_down[1] = dir_down[1];
    end
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_unit
    ct64_half #(.W(HALF_W)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_now (h_load[i]),
      .load_val (h_ld[i]),
      .step     (h_step[i]),
      .down     (h_down[i]),
      .value    (h_val[i]),
      .at_term  (at_term[i]),
      .wrap     (wrap[i])
    );

    ct64_seq #(.OVERHEAD(OVERHEAD)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (seq_go[i]),
      .restart (seq_restart[i]),
      .term    (seq_term[i]),
      .auto_rl (seq_arl[i]),
      .advance (adv[i]),
      .tc_evt  (tc_evt[i]),
      .reload  (reload_s[i]),
      .gen     (gen_s[i])
    );
  end

  ct64_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_wr    (all_wr),
    .all_wdata (all_wdata),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .halt_req  (tc_evt & ~auto_reload),
    .tc_evt    (tc_evt),
    .irq_clr   (irq_clr),
    .run       (run),
    .irq       (irq_flag)
  );

  assign count   = {h_val[1], h_val[0]};
  assign gen_out = gen_s;
endmodule

// File: rtl/ct64_chk.sv
module ct64_chk #(
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                joined,
  input logic [1:0]          load_stb,
  input logic [1:0]          auto_reload,
  input logic [HALF_W-1:0]   load_lo,
  input logic [HALF_W-1:0]   load_hi,
  input logic [2*HALF_W-1:0] count,
  input logic [1:0]          gen_out,
  input logic [1:0]          irq_flag,
  input logic [1:0]          tc_evt,
  input logic [1:0]          reload_s,
  input logic [1:0]          wrap
);
  // R10
  gen_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_out[0] |=> !gen_out[0]);

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt[0] |=> irq_flag[0]);

  // R4
  hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && !load_stb[0] && !reload_s[0] && !wrap[0]) |=> $stable(count[2*HALF_W-1:HALF_W]));

  // R5
  load_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && load_stb[0]) |=> (count == $past({load_hi, load_lo})));

  // R8
  hold_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && tc_evt[0] && !auto_reload[0] && !load_stb[0]) |=> $stable(count));

  // R11
  split_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && $past(joined)) |-> !gen_out[1]);
endmodule

bind ct64_timer ct64_chk #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .joined      (joined),
  .load_stb    (load_stb),
  .auto_reload (auto_reload),
  .load_lo     (load_lo),
  .load_hi     (load_hi),
  .count       (count),
  .gen_out     (gen_out),
  .irq_flag    (irq_flag),
  .tc_evt      (tc_evt),
  .reload_s    (reload_s),
  .wrap        (wrap)
);

// File: tb/sim_ct64_timer.sv
module sim_ct64_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cascade_on = 1'b1;
  logic        all_wr = 1'b0, all_wdata = 1'b0;
  logic [1:0]  start_stb = '0, stop_stb = '0, dir_down = 2'b11, auto_reload = 2'b11;
  logic [1:0]  load_stb = '0, irq_clr = '0;
  logic [31:0] load_lo = '0, load_hi = '0;
  logic [63:0] count;
  logic [1:0]  gen_out, irq_flag;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int q0[$], q1[$];

  ct64_timer u0 (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h cyc=%0d", tag, got, exp, cyc);
    end
  endtask

  // monitor: compares generate pulses with the scoreboard queues
  always @(negedge clk) if (rst_n) begin
    if (gen_out[0]) begin
      checks++;
      if (q0.size() == 0 || q0[0] != cyc) begin
        fails++;
        $display("FAIL R2/R3/R7 pulse0 got=%0d exp=%0d", cyc, (q0.size() != 0) ? q0[0] : -1);
      end else void'(q0.pop_front());
    end
    if (gen_out[1]) begin
      checks++;
      if (q1.size() == 0 || q1[0] != cyc) begin
        fails++;
        $display("FAIL R7/R11 pulse1 got=%0d exp=%0d", cyc, (q1.size() != 0) ? q1[0] : -1);
      end else void'(q1.pop_front());
    end
  end

  task automatic push_train(int ch, int first, int spacing, int last);
    for (int c = first; c <= last; c += spacing)
      if (ch == 0) q0.push_back(c); else q1.push_back(c);
  endtask

  task automatic queues_empty(string tag);
    chk({tag, " missing pulses"}, 64'(q0.size() + q1.size()), 64'd0);
    q0.delete(); q1.delete();
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic stop_all();
    stop_stb = 2'b11; @(negedge clk); stop_stb = '0; @(negedge clk);
  endtask

  // load and start timer 0 in one strobe; returns the first cycle showing the load
  task automatic load_go(logic [63:0] v, output int p);
    {load_hi, load_lo} = v; load_stb = 2'b01; start_stb = 2'b01;
    @(negedge clk);
    load_stb = '0; start_stb = '0;
    p = cyc;
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 gen", 64'(gen_out), 0);
    chk("R1 irq", 64'(irq_flag), 0);
    repeat (5) @(negedge clk);
    chk("R1 idle", count, 0);

    // R2 joined, down, reload: L=7
    cascade_on = 1; dir_down = 2'b11; auto_reload = 2'b11;
    load_go(64'd7, p);
    chk("R5 load shown", count, 64'd7);
    push_train(0, p + 8, 11, p + 51);
    wait_cyc(p + 8);
    chk("R10 reload value in pulse cycle", count, 64'd7);
    chk("R9 irq after tc", 64'(irq_flag[0]), 1);
    wait_cyc(p + 50);
    stop_all();
    queues_empty("R2");
    // R9 clear
    irq_clr = 2'b01; @(negedge clk); irq_clr = '0;
    chk("R9 irq cleared", 64'(irq_flag[0]), 0);

    // R4 borrow into high half
    load_go({32'd1, 32'd2}, p);
    chk("R4 borrow p0", count, {32'd1, 32'd2});
    @(negedge clk); chk("R4 borrow p1", count, {32'd1, 32'd1});
    @(negedge clk); chk("R4 borrow p2", count, {32'd1, 32'd0});
    @(negedge clk); chk("R4 borrow p3", count, {32'd0, 32'hFFFF_FFFF});
    stop_all();
    // R4 carry into high half
    dir_down = 2'b10;
    load_go({32'd0, 32'hFFFF_FFFE}, p);
    @(negedge clk); chk("R4 carry p1", count, {32'd0, 32'hFFFF_FFFF});
    @(negedge clk); chk("R4 carry p2", count, {32'd1, 32'd0});
    stop_all();

    // R3 joined up, L = max-5
    load_go(64'hFFFF_FFFF_FFFF_FFFA, p);
    push_train(0, p + 6, 9, p + 41);
    wait_cyc(p + 6);
    chk("R3 R10 reload value", count, 64'hFFFF_FFFF_FFFF_FFFA);
    wait_cyc(p + 40);
    stop_all();
    queues_empty("R3");

    // R8 hold mode, down, L=3
    dir_down = 2'b11; auto_reload = 2'b10;
    irq_clr = 2'b11; @(negedge clk); irq_clr = '0;
    load_go(64'd3, p);
    q0.push_back(p + 4);
    wait_cyc(p + 15);
    chk("R8 held at terminal", count, 0);
    chk("R8 R9 irq", 64'(irq_flag[0]), 1);
    queues_empty("R8");
    auto_reload = 2'b11;

    // R6 / R7 split mode with enable-all
    cascade_on = 0;
    load_lo = 32'd10; load_hi = 32'd20; load_stb = 2'b11;
    @(negedge clk); load_stb = '0;
    all_wr = 1; all_wdata = 0; @(negedge clk); all_wr = 0;
    repeat (4) @(negedge clk);
    chk("R6 write 0 no effect", count, {32'd20, 32'd10});
    all_wr = 1; all_wdata = 1; @(negedge clk); all_wr = 0;
    p = cyc;
    push_train(0, p + 11, 14, p + 76);
    push_train(1, p + 21, 24, p + 76);
    wait_cyc(p + 5);
    chk("R6 R7 both run independently", count, {32'd15, 32'd5});
    wait_cyc(p + 75);
    stop_all();
    queues_empty("R7");

    // R11 joined ignores timer 1 strobes
    cascade_on = 1;
    {load_hi, load_lo} = 64'd50; load_stb = 2'b01; @(negedge clk); load_stb = '0;
    load_hi = 32'd77; load_stb = 2'b10; start_stb = 2'b10;
    @(negedge clk); load_stb = '0; start_stb = '0;
    repeat (3) @(negedge clk);
    chk("R11 timer1 strobes ignored", count, 64'd50);

    // R12 stop and resume
    start_stb = 2'b01; @(negedge clk); start_stb = '0;
    p = cyc;
    chk("R12 start value", count, 64'd50);
    wait_cyc(p + 5);
    chk("R12 running", count, 64'd45);
    stop_stb = 2'b01; @(negedge clk); stop_stb = '0;
    chk("R12 last step", count, 64'd44);
    wait_cyc(p + 10);
    chk("R12 frozen", count, 64'd44);
    start_stb = 2'b01; @(negedge clk); start_stb = '0;
    wait_cyc(p + 14);
    chk("R12 resumed", count, 64'd41);
    stop_all();
    queues_empty("R11");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule